// File: doc/BRIEF.md
# Switch Management Register Access Sequencer

This block turns one logical register access, naming an internal switch device, a register within it and (for writes) a data word, into the series of management-bus transactions that the configured addressing scheme needs. It sits between a host-side requester and a single-transaction management-bus master. That master port carries one read or write at a time and answers each one with a done or an error pulse.

Three schemes are supported. In the flat scheme the device number is used as the bus address. In the paired scheme the device number is added to a strapped switch base address. In the shared scheme the switch answers at its base address only, through a command word at register 0 and a data word at register 1. There the sequencer polls the command busy flag before and after posting the command. The polling is bounded, with a fixed idle gap between attempts. The requester sees a ready flag, then a single-cycle completion or error pulse with read data or an error code.

Top module: `smi_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done`, `rsp_err` and `smi_req` are 0.
- R2: The scheme is taken at acceptance in this priority order: `cfg_dual`=1 selects paired; else `cfg_base`=0 selects flat; else `cfg_multi`=1 selects shared; else the request is rejected.
- R3: In flat mode one transaction is issued with `smi_addr` = device, `smi_reg` = register, `smi_write` = request write flag and `smi_wdata` = write data. A read returns `smi_rdata` on `rsp_rdata`.
- R4: In paired mode `smi_addr` is (`cfg_base` + device) modulo 32. Everything else is as in flat mode.
- R5: A rejected request issues no transaction and ends with `rsp_err`=1 and `rsp_err_code`=3.
- R6: A shared-mode read issues, in order: polls of register 0 at the base address until bit 15 reads 0; a write of 0x9800 | device<<5 | register to register 0; polls until bit 15 is 0; then a read of register 1, whose value is returned.
- R7: A shared-mode write issues, in order: polls until bit 15 is 0; a write of the data to register 1; a write of 0x9400 | device<<5 | register to register 0; polls until bit 15 is 0. It then reports done.
- R8: After a poll that returns bit 15 = 1, `smi_req` stays low for exactly POLL_GAP cycles before the next poll is issued.
- R9: A wait phase makes at most 16 polls. If all 16 return bit 15 = 1, the access ends with `rsp_err_code`=2 and no further transaction.
- R10: An `smi_err` on any transaction ends the access at once with `rsp_err_code`=1, and no further transaction is issued.
- R11: `req_ready` drops after acceptance and rises with the single-cycle `rsp_done` or `rsp_err` pulse. That pulse comes one cycle after the final `smi_done`. Requests offered while not ready are ignored.
- R12: While `smi_req` is high and no answer has arrived, `smi_req`, `smi_addr`, `smi_reg`, `smi_write` and `smi_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dual | input | 1 | Switch supports paired addressing |
| cfg_multi | input | 1 | Switch supports shared indirect addressing |
| cfg_base | input | 5 | Strapped switch base address |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Internal device number |
| req_reg | input | 5 | Register number within the device |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Access completed (one-cycle pulse) |
| rsp_err | output | 1 | Access failed (one-cycle pulse) |
| rsp_err_code | output | 2 | 0 none, 1 bus error, 2 timeout, 3 configuration |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` on reads |
| smi_req | output | 1 | Bus transaction request, held until answered |
| smi_addr | output | 5 | Bus address |
| smi_reg | output | 5 | Bus register number |
| smi_write | output | 1 | Bus transaction is a write |
| smi_wdata | output | 16 | Bus write data |
| smi_done | input | 1 | Bus transaction completed |
| smi_err | input | 1 | Bus transaction failed |
| smi_rdata | input | 16 | Bus read data, valid with `smi_done` |

## Verification
A wrong phase or scheme register shows up at the bus port on the very next transaction. It appears there as a wrong address, register number, direction or command word, and the bench compares each transaction against its own expected list as the transaction completes. A retry counter or gap counter that is off by one shows up as a gap of the wrong length, or as a 15th or 17th poll, within one gap period. A stuck state shows within one cycle as `req_ready` disagreeing with the bench's own record of whether an access is pending.

// File: rtl/smi_seq_pkg.sv
`timescale 1ns/1ps
package smi_seq_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned BUSY_BIT = 15;

  typedef enum logic [1:0] {
    MODE_FLAT   = 2'd0,
    MODE_PAIRED = 2'd1,
    MODE_SHARED = 2'd2,
    MODE_BAD    = 2'd3
  } acc_mode_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_CONFIG  = 2'd3
  } err_code_e;

  typedef enum logic [2:0] {
    PH_DIRECT    = 3'd0,
    PH_POLL_PRE  = 3'd1,
    PH_WDATA     = 3'd2,
    PH_CMD       = 3'd3,
    PH_POLL_POST = 3'd4,
    PH_RDATA     = 3'd5
  } phase_e;

  // register offsets inside the shared-mode window
  localparam logic [ADDR_W-1:0] WIN_CMD  = 5'd0;
  localparam logic [ADDR_W-1:0] WIN_DATA = 5'd1;

  function automatic acc_mode_e pick_mode(input logic dual, input logic multi,
                                          input logic [ADDR_W-1:0] base);
    if (dual)              return MODE_PAIRED;
    else if (base == '0)   return MODE_FLAT;
    else if (multi)        return MODE_SHARED;
    else                   return MODE_BAD;
  endfunction

  // busy | clause-22 | opcode (01 write, 10 read) | dev[9:5] | reg[4:0]
  function automatic logic [DATA_W-1:0] cmd_word(input logic wr,
                                                 input logic [ADDR_W-1:0] dev,
                                                 input logic [ADDR_W-1:0] rg);
    logic [DATA_W-1:0] w;
    w = 16'h9000 | (wr ? 16'h0400 : 16'h0800);
    w[9:5] = dev;
    w[4:0] = rg;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] paired_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [ADDR_W-1:0] dev);
    return base + dev;
  endfunction
endpackage

// File: rtl/smi_mode_sel.sv
`timescale 1ns/1ps
module smi_mode_sel
  import smi_seq_pkg::*;
(
  input  logic              cfg_dual,
  input  logic              cfg_multi,
  input  logic [ADDR_W-1:0] cfg_base,
  output acc_mode_e         mode
);
  assign mode = pick_mode(cfg_dual, cfg_multi, cfg_base);
endmodule

// File: rtl/smi_poll_ctrl.sv
`timescale 1ns/1ps
module smi_poll_ctrl #(
  parameter int unsigned POLL_TRIES = 16,
  parameter int unsigned POLL_GAP   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic try_clr,
  input  logic try_inc,
  input  logic gap_load,
  output logic last_try,
  output logic gap_zero
);
  localparam int unsigned TRY_W = (POLL_TRIES > 1) ? $clog2(POLL_TRIES) : 1;
  localparam int unsigned GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_TRIES - 1);
  localparam logic [GAP_W-1:0] GAP_INIT = GAP_W'(POLL_GAP - 1);

  logic [TRY_W-1:0] tries_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
    end else if (try_clr) begin
      tries_q <= '0;
    end else if (try_inc) begin
      tries_q <= tries_q + 1'b1;
    end
  end

  // down-counter for the idle gap between polls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (gap_load) begin
      gap_q <= GAP_INIT;
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign last_try = (tries_q == TRY_LAST);
  assign gap_zero = (gap_q == '0);
endmodule

// File: rtl/smi_txn_mux.sv
`timescale 1ns/1ps
module smi_txn_mux
  import smi_seq_pkg::*;
(
  input  phase_e            ph,
  input  acc_mode_e         mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] dev,
  input  logic [ADDR_W-1:0] rg,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] t_addr,
  output logic [ADDR_W-1:0] t_reg,
  output logic              t_write,
  output logic [DATA_W-1:0] t_data
);
  always_comb begin
    t_addr  = base;
    t_reg   = WIN_CMD;
    t_write = 1'b0;
    t_data  = '0;
    case (ph)
      PH_DIRECT: begin
        t_addr  = (mode == MODE_PAIRED) ? paired_addr(base, dev) : dev;
        t_reg   = rg;
        t_write = wr;
        t_data  = wdata;
      end
      PH_WDATA: begin
        t_reg   = WIN_DATA;
        t_write = 1'b1;
        t_data  = wdata;
      end
      PH_CMD: begin
        t_write = 1'b1;
        t_data  = cmd_word(wr, dev, rg);
      end
      PH_RDATA: t_reg = WIN_DATA;
      default: ;
    endcase
  end
endmodule

// File: rtl/smi_seq.sv
`timescale 1ns/1ps
module smi_seq #(
  parameter int unsigned POLL_TRIES = 16,
  parameter int unsigned POLL_GAP   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_dual,
  input  logic        cfg_multi,
  input  logic [4:0]  cfg_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_dev,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [1:0]  rsp_err_code,
  output logic [15:0] rsp_rdata,
  output logic        smi_req,
  output logic [4:0]  smi_addr,
  output logic [4:0]  smi_reg,
  output logic        smi_write,
  output logic [15:0] smi_wdata,
  input  logic        smi_done,
  input  logic        smi_err,
  input  logic [15:0] smi_rdata
);
  import smi_seq_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_GAP, ST_CFG} st_e;

  st_e               st_q;
  phase_e            ph_q, ph_next;
  acc_mode_e         mode_q, mode_now;
  logic              wr_q;
  logic [ADDR_W-1:0] dev_q, reg_q, base_q;
  logic [DATA_W-1:0] wdata_q;
  err_code_e         code_q;

  // named events
  logic accept, bus_ok, bus_fail, busy_seen, poll_ph, poll_busy;
  logic timeout_ev, gap_load, try_clr, finish_ok, last_try, gap_zero;

  smi_mode_sel u_mode (
    .cfg_dual (cfg_dual),
    .cfg_multi(cfg_multi),
    .cfg_base (cfg_base),
    .mode     (mode_now)
  );

  smi_poll_ctrl #(.POLL_TRIES(POLL_TRIES), .POLL_GAP(POLL_GAP)) u_poll (
    .clk     (clk),
    .rst_n   (rst_n),
    .try_clr (try_clr),
    .try_inc (gap_load),
    .gap_load(gap_load),
    .last_try(last_try),
    .gap_zero(gap_zero)
  );

  smi_txn_mux u_mux (
    .ph     (ph_q),
    .mode   (mode_q),
    .base   (base_q),
    .dev    (dev_q),
    .rg     (reg_q),
    .wr     (wr_q),
    .wdata  (wdata_q),
    .t_addr (smi_addr),
    .t_reg  (smi_reg),
    .t_write(smi_write),
    .t_data (smi_wdata)
  );

  assign req_ready  = (st_q == ST_IDLE);
  assign smi_req    = (st_q == ST_BUS);
  assign accept     = req_valid & req_ready;
  assign bus_fail   = smi_req & smi_err;
  assign bus_ok     = smi_req & smi_done & ~smi_err;
  assign busy_seen  = smi_rdata[BUSY_BIT];
  assign poll_ph    = (ph_q == PH_POLL_PRE) | (ph_q == PH_POLL_POST);
  assign poll_busy  = bus_ok & poll_ph & busy_seen;
  assign timeout_ev = poll_busy & last_try;
  assign gap_load   = poll_busy & ~last_try;
  assign try_clr    = accept | (bus_ok & poll_ph & ~busy_seen);
  assign finish_ok  = bus_ok & ((ph_q == PH_DIRECT) | (ph_q == PH_RDATA) |
                                ((ph_q == PH_POLL_POST) & ~busy_seen & wr_q));
  assign rsp_err_code = code_q;

  always_comb begin
    ph_next = ph_q;
    case (ph_q)
      PH_POLL_PRE:  ph_next = wr_q ? PH_WDATA : PH_CMD;
      PH_WDATA:     ph_next = PH_CMD;
      PH_CMD:       ph_next = PH_POLL_POST;
      PH_POLL_POST: ph_next = PH_RDATA;
      default:      ph_next = ph_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_DIRECT;
      mode_q    <= MODE_FLAT;
      wr_q      <= 1'b0;
      dev_q     <= '0;
      reg_q     <= '0;
      base_q    <= '0;
      wdata_q   <= '0;
      code_q    <= ERR_NONE;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          dev_q   <= req_dev;
          reg_q   <= req_reg;
          wdata_q <= req_wdata;
          base_q  <= cfg_base;
          mode_q  <= mode_now;
          ph_q    <= (mode_now == MODE_SHARED) ? PH_POLL_PRE : PH_DIRECT;
          st_q    <= (mode_now == MODE_BAD) ? ST_CFG : ST_BUS;
        end
        ST_CFG: begin
          st_q      <= ST_IDLE;
          rsp_err   <= 1'b1;
          code_q    <= ERR_CONFIG;
          rsp_rdata <= '0;
        end
        ST_BUS: begin
          if (bus_fail) begin
            st_q      <= ST_IDLE;
            rsp_err   <= 1'b1;
            code_q    <= ERR_BUS;
            rsp_rdata <= '0;
          end else if (timeout_ev) begin
            st_q      <= ST_IDLE;
            rsp_err   <= 1'b1;
            code_q    <= ERR_TIMEOUT;
            rsp_rdata <= '0;
          end else if (gap_load) begin
            st_q <= ST_GAP;
          end else if (finish_ok) begin
            st_q      <= ST_IDLE;
            rsp_done  <= 1'b1;
            code_q    <= ERR_NONE;
            rsp_rdata <= wr_q ? '0 : smi_rdata;
          end else if (bus_ok) begin
            ph_q <= ph_next;
          end
        end
        ST_GAP: if (gap_zero) st_q <= ST_BUS;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11: acceptance takes ready away on the next cycle
  p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R11: completion and error pulses last one cycle and never coincide
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_err) |=> !(rsp_done || rsp_err));
  p_rsp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err));

  // R12: an unanswered bus request keeps its fields
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && !smi_done && !smi_err) |=>
      (smi_req && $stable(smi_addr) && $stable(smi_reg) &&
       $stable(smi_write) && $stable(smi_wdata)));

  // R5: a rejected configuration never reaches the bus
  p_cfg_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_now == MODE_BAD) |=> !smi_req);

  // R8: a busy poll answer leaves the bus idle next cycle (unless last try)
  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && smi_done && !smi_err && poll_ph && smi_rdata[BUSY_BIT]) |=> !smi_req);

  // R10: a bus error aborts with code 1
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_req && smi_err) |=> (!smi_req && rsp_err && rsp_err_code == 2'd1));

  // R9: the final busy poll ends with the timeout code
  p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (rsp_err && rsp_err_code == 2'd2));
endmodule

// File: tb/test_smi_seq.sv
`timescale 1ns/1ps
module test_smi_seq;
  localparam int GAP = 8;
  localparam int LAT = 2;
  localparam logic [4:0] WB = 5'h04;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dual = 0, cfg_multi = 0;
  logic [4:0] cfg_base = 0;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_dev = 0, req_reg = 0;
  logic [15:0] req_wdata = 0;
  logic req_ready, rsp_done, rsp_err, smi_req, smi_write;
  logic [1:0] rsp_err_code;
  logic [15:0] rsp_rdata, smi_wdata;
  logic [4:0] smi_addr, smi_reg;
  logic smi_done = 0, smi_err = 0;
  logic [15:0] smi_rdata = 0;

  always #2.5 clk = ~clk;

  smi_seq #(.POLL_TRIES(16), .POLL_GAP(GAP)) i_smi_seq (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_multi(cfg_multi),
    .cfg_base(cfg_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_err_code(rsp_err_code), .rsp_rdata(rsp_rdata), .smi_req(smi_req),
    .smi_addr(smi_addr), .smi_reg(smi_reg), .smi_write(smi_write),
    .smi_wdata(smi_wdata), .smi_done(smi_done), .smi_err(smi_err),
    .smi_rdata(smi_rdata));

  int total = 0, bad = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural bus slave and reference state
  typedef struct { logic [4:0] a; logic [4:0] r; bit w; logic [15:0] d; } txn_t;
  txn_t exp_q[$];
  logic [15:0] mem [32][32];
  logic [15:0] win_data;
  bit ind_mode = 0;
  int busy_left = 0, post_busy = 0, err_at = 0, txn_idx = 0, lat_cnt = 0;
  bit gap_pending = 0;
  int gap_low = 0, last_done_cyc = 0;

  function automatic logic [15:0] init_val(input int a, input int r);
    return 16'(a * 1024 + r * 7 + 16'h0111);
  endfunction

  task automatic push(input logic [4:0] a, input logic [4:0] r, input bit w,
                      input logic [15:0] d);
    txn_t t;
    t.a = a; t.r = r; t.w = w; t.d = d;
    exp_q.push_back(t);
  endtask

  task automatic push_polls(input int n);
    for (int i = 0; i < n; i++) push(WB, 5'd0, 1'b0, 16'h0);
  endtask

  always @(negedge clk) begin
    if (!smi_req) begin
      lat_cnt = 0; smi_done = 0; smi_err = 0;
      if (gap_pending) gap_low++;
    end else begin
      if (gap_pending) begin
        check(gap_low == GAP, "R8", "idle cycles between polls", gap_low, GAP);
        gap_pending = 0;
      end
      if (lat_cnt < LAT) begin
        lat_cnt++; smi_done = 0; smi_err = 0;
      end else begin
        lat_cnt = 0;
        txn_idx++;
        last_done_cyc = cyc;
        if (exp_q.size() == 0) begin
          check(0, "R11", "unexpected bus transaction", {smi_addr, smi_reg}, 0);
        end else begin
          txn_t t;
          t = exp_q.pop_front();
          check(smi_addr == t.a && smi_reg == t.r && smi_write == t.w,
                "R12", "bus addr/reg/dir", {smi_addr, smi_reg, smi_write},
                {t.a, t.r, t.w});
          if (t.w) check(smi_wdata == t.d, "R7", "bus write data", smi_wdata, t.d);
        end
        if (txn_idx == err_at) begin
          smi_err = 1; smi_done = 0;
        end else begin
          smi_done = 1; smi_err = 0;
          if (ind_mode && smi_addr == WB) begin
            if (smi_reg == 5'd0 && !smi_write) begin
              if (busy_left > 0) begin
                busy_left--; smi_rdata = 16'h8000; gap_pending = 1; gap_low = 0;
              end else smi_rdata = 16'h0000;
            end else if (smi_reg == 5'd0) begin
              if (smi_wdata[11:10] == 2'b10) win_data = mem[smi_wdata[9:5]][smi_wdata[4:0]];
              else if (smi_wdata[11:10] == 2'b01) mem[smi_wdata[9:5]][smi_wdata[4:0]] = win_data;
              busy_left = post_busy;
            end else if (smi_write) win_data = smi_wdata;
            else smi_rdata = win_data;
          end else begin
            if (smi_write) mem[smi_addr][smi_reg] = smi_wdata;
            else smi_rdata = mem[smi_addr][smi_reg];
          end
        end
      end
    end
  end

  // per-cycle comparison of the handshake against the reference pending flag
  bit pending = 0, prev_rsp = 0, got_rsp = 0, rsp_was_done = 0;
  logic [1:0] got_code;
  logic [15:0] got_rd;
  int rsp_cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit now;
      now = rsp_done | rsp_err;
      check(req_ready == !(pending && !now), "R11", "ready vs pending", req_ready,
            !(pending && !now));
      if (smi_req && !pending) check(0, "R11", "bus active while idle", 1, 0);
      if (now) begin
        check(!prev_rsp, "R11", "response pulse width", prev_rsp, 0);
        got_rsp = 1; rsp_was_done = rsp_done; got_code = rsp_err_code;
        got_rd = rsp_rdata; rsp_cyc = cyc; pending = 0;
      end
      prev_rsp = now;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_req(input bit w, input logic [4:0] dev, input logic [4:0] rg,
                        input logic [15:0] wd, input int pre, input int post,
                        input int errat, input bit junk);
    got_rsp = 0; gap_pending = 0; busy_left = pre; post_busy = post;
    err_at = errat; txn_idx = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_dev = dev; req_reg = rg; req_wdata = wd;
    @(posedge clk);
    pending = 1;
    #1;
    if (junk) begin
      req_write = ~w; req_dev = ~dev; req_wdata = ~wd;
      repeat (20) @(posedge clk);
      #1;
    end
    req_valid = 0;
    for (int n = 0; n < 3000 && !got_rsp; n++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_rsp(input string tag, input bit done, input logic [1:0] code,
                            input bit chk_rd, input logic [15:0] rd, input bit timed);
    check(got_rsp && rsp_was_done == done, tag, "done/err kind", {got_rsp, rsp_was_done},
          {1'b1, done});
    check(got_code == code, tag, "error code", got_code, code);
    if (chk_rd) check(got_rd == rd, tag, "read data", got_rd, rd);
    check(exp_q.size() == 0, tag, "missing bus transactions", exp_q.size(), 0);
    if (timed) check(rsp_cyc == last_done_cyc + 1, "R11", "response latency",
                     rsp_cyc, last_done_cyc + 1);
    exp_q.delete();
  endtask

  initial begin
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++) mem[a][r] = init_val(a, r);
    win_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(rsp_done == 0 && rsp_err == 0, "R1", "no response after reset",
          {rsp_done, rsp_err}, 0);
    check(smi_req == 0, "R1", "bus idle after reset", smi_req, 0);

    // flat mode write then read (R3)
    push(5'd3, 5'd4, 1, 16'hBEEF);
    do_req(1, 5'd3, 5'd4, 16'hBEEF, 0, 0, 0, 0);
    expect_rsp("R3", 1, 2'd0, 0, 0, 1);
    push(5'd3, 5'd4, 0, 0);
    do_req(0, 5'd3, 5'd4, 0, 0, 0, 0, 0);
    expect_rsp("R3", 1, 2'd0, 1, 16'hBEEF, 1);

    // base 0 with shared capability still flat (R2)
    cfg_multi = 1;
    push(5'd7, 5'd1, 1, 16'h1234);
    do_req(1, 5'd7, 5'd1, 16'h1234, 0, 0, 0, 0);
    expect_rsp("R2", 1, 2'd0, 0, 0, 1);

    // paired wins over others (R2, R4)
    cfg_dual = 1; cfg_base = 5'h10;
    push(5'h15, 5'd2, 0, 0);
    do_req(0, 5'd5, 5'd2, 0, 0, 0, 0, 0);
    expect_rsp("R4", 1, 2'd0, 1, init_val(5'h15, 2), 1);
    // paired address wraps modulo 32 (R4)
    cfg_base = 5'h1C;
    push(5'h02, 5'd9, 1, 16'h5A5A);
    do_req(1, 5'd6, 5'd9, 16'h5A5A, 0, 0, 0, 0);
    expect_rsp("R4", 1, 2'd0, 0, 0, 1);
    cfg_dual = 0; cfg_base = 0;
    push(5'h02, 5'd9, 0, 0);
    do_req(0, 5'd2, 5'd9, 0, 0, 0, 0, 0);
    expect_rsp("R4", 1, 2'd0, 1, 16'h5A5A, 1);

    // rejected configuration (R5)
    cfg_multi = 0; cfg_base = WB;
    do_req(1, 5'd1, 5'd1, 16'h1111, 0, 0, 0, 0);
    expect_rsp("R5", 0, 2'd3, 0, 0, 0);

    // shared mode write (R7, R8)
    cfg_multi = 1; ind_mode = 1;
    push_polls(3); push(WB, 5'd1, 1, 16'hC0DE);
    push(WB, 5'd0, 1, 16'h9400 | (16'd9 << 5) | 16'd17); push_polls(2);
    do_req(1, 5'd9, 5'd17, 16'hC0DE, 2, 1, 0, 0);
    expect_rsp("R7", 1, 2'd0, 0, 0, 1);

    // shared mode read (R6)
    push_polls(1); push(WB, 5'd0, 1, 16'h9800 | (16'd9 << 5) | 16'd17);
    push_polls(4); push(WB, 5'd1, 0, 0);
    do_req(0, 5'd9, 5'd17, 0, 0, 3, 0, 0);
    expect_rsp("R6", 1, 2'd0, 1, 16'hC0DE, 1);

    // timeout before posting (R9)
    push_polls(16);
    do_req(0, 5'd1, 5'd2, 0, 20, 0, 0, 0);
    expect_rsp("R9", 0, 2'd2, 0, 0, 1);

    // timeout after posting (R9)
    push_polls(1); push(WB, 5'd1, 1, 16'h0F0F);
    push(WB, 5'd0, 1, 16'h9400 | (16'd3 << 5) | 16'd8); push_polls(16);
    do_req(1, 5'd3, 5'd8, 16'h0F0F, 0, 30, 0, 0);
    expect_rsp("R9", 0, 2'd2, 0, 0, 1);

    // bus error on the command write (R10)
    push_polls(1); push(WB, 5'd0, 1, 16'h9800 | (16'd4 << 5) | 16'd6);
    do_req(0, 5'd4, 5'd6, 0, 0, 0, 2, 0);
    expect_rsp("R10", 0, 2'd1, 0, 0, 1);

    // requests offered while busy are ignored (R11)
    push_polls(4); push(WB, 5'd1, 1, 16'h7777);
    push(WB, 5'd0, 1, 16'h9400 | (16'd2 << 5) | 16'd3); push_polls(1);
    do_req(1, 5'd2, 5'd3, 16'h7777, 3, 0, 0, 1);
    expect_rsp("R11", 1, 2'd0, 0, 0, 1);
    repeat (10) @(negedge clk);
    check(mem[2][3] == 16'h7777, "R11", "held request landed intact", mem[2][3], 16'h7777);
    check(mem[29][28] == init_val(29, 28), "R11", "junk request had no effect",
          mem[29][28], init_val(29, 28));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule